// File: doc/BRIEF.md
# Compact 32-bit Rijndael-style encryptor

This block encrypts one 32-bit block under a 32-bit key. It uses a reduced form of the Rijndael cipher. The state holds four bytes in two columns of two rows. Each column is one 16-bit word, with the row-0 byte in the high half and the row-1 byte in the low half. Plaintext and key arrive on a single 16-bit stream input, one word per accepted beat. A two-bit beat counter steers each word into the state register or the key register. The fourth accepted beat starts the encryption.

After an initial key XOR the block runs a fixed number of rounds. Each round substitutes every state byte, rotates row 1 by one byte, mixes each column and XORs in the round key. The round key is generated one step ahead of its use. The design has only two byte-substitution units, and the key path and the state path share them, so each round takes three clock cycles:

- key update
- substitution of column 0, written back into the state register
- substitution of column 1, combined with the shift, the mix and the key XOR

A one-cycle `done` pulse marks a fresh ciphertext. The ciphertext output then holds until the next encryption completes.

The input is a valid/ready stream. A beat transfers on a rising edge where both `in_valid` and `in_ready` are high. The sender may idle between beats, and `in_data` is only sampled on a transfer. `in_ready` is high whenever no encryption is in flight. It drops after the fourth beat and rises again in the same cycle that `done` is high. While `in_ready` is low, the block neither samples nor counts input.

Top module: `rjn32_encrypt`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0 and `ct` is 0.
- R2: The beats are taken in this order: plaintext column 0, plaintext column 1, key column 0, key column 1. In each 16-bit word, bits 15:8 hold the row-0 byte and bits 7:0 hold the row-1 byte. Only cycles with both `in_valid` and `in_ready` high count as beats, so idle gaps between beats do not change the result.
- R3: From the transfer of the fourth beat until `done` is high, `in_ready` is 0. Any `in_valid`/`in_data` activity in that window has no effect on the ciphertext or on the next load.
- R4: The ciphertext is built in stages:
  - The state starts as plaintext XOR key.
  - Each round applies the S-box to all four bytes.
  - It then swaps the two row-1 bytes, so the new column 0 is {row0 of col0, row1 of col1} and the new column 1 is {row0 of col1, row1 of col0}.
  - It then mixes each column {x,y} into {3x^2y, 2x^3y} over GF(2^8) with polynomial 0x11B.
  - Finally it XORs in the round key.
- R5: For each round, the new key column 0 is old column 0 XOR {S(old col1 low byte), S(old col1 high byte)} XOR {rc, 8'h00}. The new key column 1 is old column 1 XOR new column 0. rc is 0x02 in round 1 and is multiplied by x (mod 0x11B) for each later round.
- R6: There are 10 rounds, and the last one skips column mixing.
- R7: `done` is high for exactly one cycle. It rises 30 clock edges after the edge that transfers the fourth beat.
- R8: `ct` holds its value except at the edge that raises `done`.
- R9: The S-box is the standard one: the multiplicative inverse in GF(2^8) (0 maps to 0), followed by the affine map with constant 0x63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sender has a word on `in_data` |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | 16 | Plaintext or key column word |
| ct | output | 32 | Ciphertext, column 0 in bits 31:16 |
| done | output | 1 | One-cycle pulse when `ct` is updated |

## Verification
The bench compares the output with a bench-side model for all-zero, all-ones and mixed inputs. A wrong S-box, a wrong row swap, a wrong mix matrix, a missing mix skip in the last round, or an off-by-one round constant all give the wrong ciphertext. The bench also inserts idle gaps between beats; a design that counted every cycle instead of every transfer would load the words into the wrong slots. It drives garbage with `in_valid` high during an encryption; a design that did not gate input would corrupt the state or skew the next load. The bench also measures the exact `done` latency and pulse width, and checks that `ct` holds after completion, which exposes a phase counter that is off by one or a ciphertext register that follows the internal state.

// File: rtl/rjn32_pkg.sv
package rjn32_pkg;

  typedef enum logic [1:0] {PH_KEY, PH_COL0, PH_COL1} phase_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // x^254 is the inverse in GF(2^8) and maps 0 to 0
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] p;
    logic [7:0] r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

endpackage

// File: rtl/rjn32_sbox.sv
module rjn32_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [7:0] inv;

  always_comb begin
    inv  = rjn32_pkg::ginv(din);
    dout = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end
endmodule

// File: rtl/rjn32_keystep.sv
module rjn32_keystep (
  input  logic [31:0] key_i,
  input  logic [15:0] sub_rot,
  input  logic [7:0]  rc,
  output logic [31:0] key_o
);
  logic [15:0] w0;

  always_comb begin
    w0    = key_i[31:16] ^ sub_rot ^ {rc, 8'h00};
    key_o = {w0, key_i[15:0] ^ w0};
  end
endmodule

// File: rtl/rjn32_mixshift.sv
module rjn32_mixshift (
  input  logic [15:0] col0_sub,
  input  logic [15:0] col1_sub,
  input  logic [31:0] rkey,
  input  logic        last,
  output logic [31:0] st_o
);
  import rjn32_pkg::*;

  logic [15:0] sh0, sh1, mx0, mx1;

  always_comb begin
    sh0 = {col0_sub[15:8], col1_sub[7:0]};
    sh1 = {col1_sub[15:8], col0_sub[7:0]};
    mx0 = {gmul(sh0[15:8], 8'd3) ^ xtime(sh0[7:0]),
           xtime(sh0[15:8]) ^ gmul(sh0[7:0], 8'd3)};
    mx1 = {gmul(sh1[15:8], 8'd3) ^ xtime(sh1[7:0]),
           xtime(sh1[15:8]) ^ gmul(sh1[7:0], 8'd3)};
    st_o = (last ? {sh0, sh1} : {mx0, mx1}) ^ rkey;
  end
endmodule

// File: rtl/rjn32_encrypt.sv
module rjn32_encrypt #(
  parameter int          NROUNDS  = 10,
  parameter logic [7:0]  RC_FIRST = 8'h02,
  parameter int          NSBOX    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  output logic [31:0] ct,
  output logic        done
);
  import rjn32_pkg::*;

  localparam int RW = $clog2(NROUNDS + 1);

  logic          busy;
  logic [1:0]    load_cnt;
  phase_e        phase;
  logic [RW-1:0] round;
  logic [7:0]    rc;
  logic [31:0]   st, key, key_nxt, st_nxt;
  logic [15:0]   sb_in, sb_out;
  logic          take;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;

  always_comb begin
    case (phase)
      PH_KEY:  sb_in = {key[7:0], key[15:8]};
      PH_COL0: sb_in = st[31:16];
      default: sb_in = st[15:0];
    endcase
  end

  for (genvar g = 0; g < NSBOX; g++) begin : g_sbox
    rjn32_sbox u_sbox (.din(sb_in[8*g +: 8]), .dout(sb_out[8*g +: 8]));
  end

  rjn32_keystep u_key (.key_i(key), .sub_rot(sb_out), .rc(rc), .key_o(key_nxt));

  rjn32_mixshift u_mix (
    .col0_sub(st[31:16]), .col1_sub(sb_out), .rkey(key),
    .last(round == RW'(NROUNDS)), .st_o(st_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      load_cnt <= 2'd0;
      phase    <= PH_KEY;
      round    <= '0;
      rc       <= RC_FIRST;
      st       <= '0;
      key      <= '0;
      ct       <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        load_cnt <= load_cnt + 2'd1;
        case (load_cnt)
          2'd0: st[31:16]  <= in_data;
          2'd1: st[15:0]   <= in_data;
          2'd2: key[31:16] <= in_data;
          default: begin
            key[15:0] <= in_data;
            st        <= st ^ {key[31:16], in_data};
            busy      <= 1'b1;
            phase     <= PH_KEY;
            round     <= RW'(1);
            rc        <= RC_FIRST;
          end
        endcase
      end else if (busy) begin
        case (phase)
          PH_KEY: begin
            key   <= key_nxt;
            rc    <= xtime(rc);
            phase <= PH_COL0;
          end
          PH_COL0: begin
            st[31:16] <= sb_out;
            phase     <= PH_COL1;
          end
          default: begin
            st    <= st_nxt;
            phase <= PH_KEY;
            round <= round + RW'(1);
            if (round == RW'(NROUNDS)) begin
              ct   <= st_nxt;
              done <= 1'b1;
              busy <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rjn32_encrypt_chk.sv
module rjn32_encrypt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  load_cnt,
  input logic [31:0] ct,
  input logic        done
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ct));

  // R3
  busy_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && load_cnt == 2'd3) |=> !in_ready);

  // R3
  ready_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> done);

  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready && $past(!in_ready));
endmodule

bind rjn32_encrypt rjn32_encrypt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .load_cnt(load_cnt), .ct(ct), .done(done)
);

// File: tb/tb_rjn32_encrypt.sv
module tb_rjn32_encrypt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [31:0] ct;
  logic        done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rjn32_encrypt dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
                     .in_data(in_data), .ct(ct), .done(done));

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11B << (i - 8));
    return p[7:0];
  endfunction

  // R9 reference substitution: search for the inverse, then the affine map
  function automatic logic [7:0] m_sb(input logic [7:0] x);
    logic [7:0] v = 8'h00;
    logic [7:0] r;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) v = 8'(y);
    r = 8'h63;
    for (int s = 0; s < 5; s++) r = r ^ ((v << s) | (v >> (8 - s)));
    return r;
  endfunction

  function automatic logic [15:0] m_mix(input logic [15:0] c);
    return {m_mul(c[15:8], 8'd3) ^ m_mul(c[7:0], 8'd2),
            m_mul(c[15:8], 8'd2) ^ m_mul(c[7:0], 8'd3)};
  endfunction

  // R4 R5 R6 reference cipher
  function automatic logic [31:0] m_enc(input logic [31:0] p, input logic [31:0] k);
    logic [31:0] s = p ^ k;
    logic [15:0] w0 = k[31:16];
    logic [15:0] w1 = k[15:0];
    logic [15:0] c0, c1;
    logic [7:0] rc = 8'h02;
    for (int r = 1; r <= 10; r++) begin
      w0 = w0 ^ {m_sb(w1[7:0]), m_sb(w1[15:8])} ^ {rc, 8'h00};
      w1 = w1 ^ w0;
      rc = m_mul(rc, 8'h02);
      c0 = {m_sb(s[31:24]), m_sb(s[7:0])};
      c1 = {m_sb(s[15:8]), m_sb(s[23:16])};
      if (r < 10) begin c0 = m_mix(c0); c1 = m_mix(c1); end
      s = {c0, c1} ^ {w0, w1};
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // send one beat, caller at a falling edge; returns at the falling edge after transfer
  task automatic send(input logic [15:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // full encryption with optional idle gap; optional garbage while busy
  task automatic run_enc(input logic [31:0] p, input logic [31:0] k, input int gap,
                         input bit noise, input string tag);
    logic [31:0] exp = m_enc(p, k);
    logic [15:0] words [4] = '{p[31:16], p[15:0], k[31:16], k[15:0]};
    int cyc = 0;
    bit rdy_seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      send(words[i]);
      if (gap > 0 && i < 3) begin
        in_valid = 1'b0;
        in_data  = 16'hDEAD;
        repeat (gap) @(negedge clk);
      end
    end
    in_valid = noise;
    in_data  = 16'hBEEF;
    while (!done && cyc < 100) begin
      if (in_ready) rdy_seen = 1'b1;
      in_data = in_data + 16'h1357;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    chk(!rdy_seen, {tag, " R3 in_ready low while busy"}, 32'(rdy_seen), 32'd0);
    chk(cyc == 30, {tag, " R7 done latency"}, 32'(cyc), 32'd30);
    chk(ct == exp, {tag, " R4 R5 R6 R9 ciphertext"}, ct, exp);
    @(negedge clk);
    chk(!done, {tag, " R7 done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
    chk(ct == 32'd0, "R1 ct", ct, 32'd0);
  endtask

  task automatic t_patterns();
    run_enc(32'h0000_0000, 32'h0000_0000, 0, 1'b0, "zeros");
    run_enc(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0, "ones");
    run_enc(32'h0123_4567, 32'h89AB_CDEF, 0, 1'b0, "mixed");
    run_enc(32'h5300_0000, 32'h0000_0001, 0, 1'b0, "sparse");
  endtask

  task automatic t_gaps();
    run_enc(32'hA5C3_1E7F, 32'h3C96_0F12, 2, 1'b0, "R2 gaps");
  endtask

  task automatic t_busy_noise();
    run_enc(32'h1122_3344, 32'h5566_7788, 0, 1'b1, "R3 noise");
    run_enc(32'hCAFE_F00D, 32'h0BAD_BEEF, 0, 1'b0, "R3 after noise");
  endtask

  task automatic t_hold();
    logic [31:0] held = ct;
    bit moved = 1'b0;
    in_valid = 1'b0;
    in_data  = 16'h7777;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ct != held || done) moved = 1'b1;
    end
    chk(!moved, "R8 ct holds while idle", ct, held);
    // partial load must not disturb ct
    send(16'h1234);
    send(16'h5678);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(ct == held, "R8 ct holds during load", ct, held);
    send(16'h9ABC);
    send(16'hDEF0);
    in_valid = 1'b0;
    for (int i = 0; i < 29; i++) begin
      if (ct != held) moved = 1'b1;
      @(negedge clk);
    end
    chk(!moved, "R8 ct holds while busy", ct, held);
    @(negedge clk);
    chk(done && ct == m_enc(32'h1234_5678, 32'h9ABC_DEF0), "R8 ct updates with done",
        ct, m_enc(32'h1234_5678, 32'h9ABC_DEF0));
    @(negedge clk);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_gaps();
    t_busy_noise();
    t_hold();
    summary();
  end
endmodule